// File: doc/BRIEF.md
# Byte-wide memory word loader

This block fills an on-chip program RAM from an external memory that is only one byte wide. After a start pulse it reads consecutive bytes from a fixed external window and gathers every three bytes into one 24-bit word. It writes that word into the RAM, and the RAM address starts at zero and climbs by one for each word. By default the window begins at byte address $C000 and holds 1536 bytes, which load 512 words. When the last word is stored, a done flag goes high and stays high.

The external memory is read with a request/valid handshake. The loader asserts a request and presents the byte address. It keeps both steady until the memory answers with a valid pulse, so any number of wait states is absorbed. The decision to use this loader is made upstream. A system typically makes it by testing the top bit of the word found at the first window address.

Top module: `eprom_word_loader`

## Requirements
- R1: While reset is applied and after it is released, `done`, `ext_req` and `ram_we` are low until a start pulse arrives.
- R2: A start pulse while idle or done begins reading at byte address BASE_ADDR ($C000). The address rises by exactly one for each accepted byte, so byte k of word n is read from BASE_ADDR + 3n + k.
- R3: While `ext_req` is high and `ext_valid` is low, `ext_req` stays high in the next cycle and `ext_addr` does not change.
- R4: The first byte accepted for a word lands in `ram_wdata[7:0]`, the second in `[15:8]` and the third in `[23:16]`.
- R5: `ram_we` is high for exactly the one cycle that follows acceptance of each word's third byte, and at no other time. `ram_addr` runs 0, 1, 2 and on up to DEPTH-1, one value per write.
- R6: A pulse on `ext_valid` while `ext_req` is low is ignored: no byte is taken, no address advances and no packed word changes.
- R7: `done` rises in the cycle after the write to address DEPTH-1. It stays high, with `ext_req` and `ram_we` low, until the next start pulse.
- R8: A start pulse while a load is in progress has no effect, and the address and word sequence carries on.
- R9: A start pulse while `done` is high starts a new full load from BASE_ADDR and RAM address 0.
- R10: A complete load issues exactly 3 × DEPTH byte reads and DEPTH RAM writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins a load when idle or done |
| ext_req | output | 1 | Byte read request to external memory |
| ext_addr | output | EXT_AW (16) | External byte address |
| ext_valid | input | 1 | External byte present; taken while `ext_req` is high |
| ext_data | input | BYTE_W (8) | External byte |
| ram_we | output | 1 | Program RAM write strobe |
| ram_addr | output | log2(DEPTH) (9) | Program RAM word address |
| ram_wdata | output | WORD_W (24) | Packed word to write |
| done | output | 1 | Load complete; held until next start |

## Verification
A byte is taken on the rising edge where `ext_req` and `ext_valid` are both high. A new `ext_addr` shows one cycle later. After a third byte, `ram_we` with the packed word shows in the cycle that follows the accepting edge. `done` appears one cycle after the final write. The bench drives `ext_valid` and `ext_data` at falling edges. At each falling edge it first samples the outputs against what it drove at the previous falling edge, then drives again. This means every expected write, address step and done rise is checked exactly one edge after the event that causes it.

// File: rtl/eprom_ld_pkg.sv
package eprom_ld_pkg;

   typedef enum logic [1:0] {
      LD_IDLE  = 2'd0,
      LD_FETCH = 2'd1,
      LD_STORE = 2'd2,
      LD_DONE  = 2'd3
   } ld_state_e;

   function automatic int unsigned lane_bits(input int unsigned lanes);
      return (lanes > 1) ? $clog2(lanes) : 1;
   endfunction

endpackage

// File: rtl/ld_ctrl.sv
module ld_ctrl
   import eprom_ld_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic ext_valid,
   input  logic last_lane,
   input  logic last_word,
   output logic ext_req,
   output logic take,
   output logic store,
   output logic restart,
   output logic done
);

   ld_state_e state_q, state_d;

   always_comb begin
      restart = start && (state_q == LD_IDLE || state_q == LD_DONE);
      ext_req = (state_q == LD_FETCH);
      take    = ext_req && ext_valid;
      store   = (state_q == LD_STORE);
      done    = (state_q == LD_DONE);
   end

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         LD_IDLE:  if (start) state_d = LD_FETCH;
         LD_FETCH: if (take && last_lane) state_d = LD_STORE;
         LD_STORE: state_d = last_word ? LD_DONE : LD_FETCH;
         LD_DONE:  if (start) state_d = LD_FETCH;
         default:  state_d = LD_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= LD_IDLE;
      else        state_q <= state_d;
   end

   // R3: an unanswered request is held
   p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ext_req && !ext_valid |=> ext_req);

   // R7: the done flag persists without start
   p_done_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done && !start |=> done);

endmodule

// File: rtl/ld_cursor.sv
module ld_cursor
   import eprom_ld_pkg::*;
#(
   parameter int unsigned             BPW       = 3,
   parameter int unsigned             DEPTH     = 512,
   parameter int unsigned             EXT_AW    = 16,
   parameter logic [EXT_AW-1:0]       BASE_ADDR = 16'hC000,
   localparam int unsigned            LANE_W    = lane_bits(BPW),
   localparam int unsigned            WORD_AW   = $clog2(DEPTH)
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               restart,
   input  logic               take,
   input  logic               store,
   output logic [EXT_AW-1:0]  ext_addr,
   output logic [LANE_W-1:0]  lane_idx,
   output logic [WORD_AW-1:0] word_idx,
   output logic               last_lane,
   output logic               last_word
);

   localparam logic [LANE_W-1:0]  LANE_LAST = LANE_W'(BPW - 1);
   localparam logic [WORD_AW-1:0] WORD_LAST = WORD_AW'(DEPTH - 1);

   assign last_lane = (lane_idx == LANE_LAST);
   assign last_word = (word_idx == WORD_LAST);

   // byte address: advanced per accepted byte, never multiplied
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ext_addr <= BASE_ADDR;
      else if (restart) ext_addr <= BASE_ADDR;
      else if (take)    ext_addr <= ext_addr + EXT_AW'(1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       lane_idx <= '0;
      else if (restart) lane_idx <= '0;
      else if (take)    lane_idx <= last_lane ? '0 : lane_idx + LANE_W'(1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       word_idx <= '0;
      else if (restart) word_idx <= '0;
      else if (store)   word_idx <= word_idx + WORD_AW'(1);
   end

   // R2: each accepted byte advances the address by one
   p_addr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> ext_addr == $past(ext_addr) + EXT_AW'(1));

   // R5: word index steps once per store
   p_word_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
      store |=> word_idx == $past(word_idx) + WORD_AW'(1));

endmodule

// File: rtl/ld_packer.sv
module ld_packer
   import eprom_ld_pkg::*;
#(
   parameter int unsigned  BYTE_W = 8,
   parameter int unsigned  BPW    = 3,
   localparam int unsigned LANE_W = lane_bits(BPW),
   localparam int unsigned WORD_W = BYTE_W * BPW
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              take,
   input  logic [LANE_W-1:0] lane_idx,
   input  logic [BYTE_W-1:0] byte_in,
   output logic [WORD_W-1:0] word_o
);

   // lane k (first byte = lane 0) fills bits [k*BYTE_W +: BYTE_W]
   for (genvar k = 0; k < BPW; k++) begin : g_lane
      logic [BYTE_W-1:0] lane_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                  lane_q <= '0;
         else if (take && lane_idx == LANE_W'(k))     lane_q <= byte_in;
      end
      assign word_o[k*BYTE_W +: BYTE_W] = lane_q;
   end

   // R6: nothing changes without an accepted byte
   p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !take |=> $stable(word_o));

endmodule

// File: rtl/eprom_word_loader.sv
module eprom_word_loader
   import eprom_ld_pkg::*;
#(
   parameter int unsigned       BYTE_W    = 8,
   parameter int unsigned       WORD_W    = 24,
   parameter int unsigned       DEPTH     = 512,
   parameter int unsigned       EXT_AW    = 16,
   parameter logic [EXT_AW-1:0] BASE_ADDR = 16'hC000,
   localparam int unsigned      BPW       = WORD_W / BYTE_W,
   localparam int unsigned      LANE_W    = lane_bits(BPW),
   localparam int unsigned      WORD_AW   = $clog2(DEPTH)
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   output logic               ext_req,
   output logic [EXT_AW-1:0]  ext_addr,
   input  logic               ext_valid,
   input  logic [BYTE_W-1:0]  ext_data,
   output logic               ram_we,
   output logic [WORD_AW-1:0] ram_addr,
   output logic [WORD_W-1:0]  ram_wdata,
   output logic               done
);

   localparam longint unsigned WIN_END  = longint'(BASE_ADDR) + longint'(DEPTH) * longint'(BPW);
   localparam longint unsigned ADDR_TOP = longint'(1) << EXT_AW;

   if (WORD_W % BYTE_W != 0) begin : g_bad_split
      $error("WORD_W must be a whole number of bytes");
   end
   if (BPW < 1) begin : g_bad_bpw
      $error("WORD_W must hold at least one byte");
   end
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("DEPTH must be a power of two of at least 2");
   end
   if (WIN_END > ADDR_TOP) begin : g_bad_window
      $error("external window does not fit in EXT_AW bits");
   end

   logic              take, store, restart;
   logic              last_lane, last_word;
   logic [LANE_W-1:0] lane_idx;

   ld_ctrl i_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .ext_valid (ext_valid),
      .last_lane (last_lane),
      .last_word (last_word),
      .ext_req   (ext_req),
      .take      (take),
      .store     (store),
      .restart   (restart),
      .done      (done)
   );

   ld_cursor #(
      .BPW       (BPW),
      .DEPTH     (DEPTH),
      .EXT_AW    (EXT_AW),
      .BASE_ADDR (BASE_ADDR)
   ) i_cursor (
      .clk       (clk),
      .rst_n     (rst_n),
      .restart   (restart),
      .take      (take),
      .store     (store),
      .ext_addr  (ext_addr),
      .lane_idx  (lane_idx),
      .word_idx  (ram_addr),
      .last_lane (last_lane),
      .last_word (last_word)
   );

   ld_packer #(
      .BYTE_W (BYTE_W),
      .BPW    (BPW)
   ) i_packer (
      .clk      (clk),
      .rst_n    (rst_n),
      .take     (take),
      .lane_idx (lane_idx),
      .byte_in  (ext_data),
      .word_o   (ram_wdata)
   );

   assign ram_we = store;

   // R3: address held while waiting
   p_addr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ext_req && !ext_valid |=> $stable(ext_addr));

   // R5: a write follows an accepted byte and lasts one cycle
   p_we_after_byte_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ram_we |-> $past(ext_req && ext_valid));
   p_we_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ram_we |=> !ram_we);

   // R7: quiet outputs while done
   p_done_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !ext_req && !ram_we);

   // R8: start during a mid-load write does not disturb the next fetch
   p_busy_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ram_we && start && ram_addr != WORD_AW'(DEPTH - 1) |=> ext_req && !done);

endmodule

// File: tb/test_eprom_word_loader.sv
module test_eprom_word_loader;

   localparam int          CLK_PERIOD = 10;
   localparam int          DEPTH      = 512;
   localparam int          BPW        = 3;
   localparam logic [15:0] BASE       = 16'hC000;
   localparam int          N_RUNS     = 4;
   // per run: [15:8] data seed, [7:4] max wait states, [0] stray valid pulses
   localparam logic [15:0] RUNS [N_RUNS] = '{16'h00_00, 16'h5A_31, 16'hC3_70, 16'h17_11};

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        ext_req;
   logic [15:0] ext_addr;
   logic        ext_valid = 1'b0;
   logic [7:0]  ext_data = 8'h00;
   logic        ram_we;
   logic [8:0]  ram_addr;
   logic [23:0] ram_wdata;
   logic        done;

   int n_checks = 0;
   int n_errors = 0;

   eprom_word_loader i_eprom_word_loader (
      .clk(clk), .rst_n(rst_n), .start(start),
      .ext_req(ext_req), .ext_addr(ext_addr), .ext_valid(ext_valid), .ext_data(ext_data),
      .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata), .done(done)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic chk(input bit ok, input string rq, input string what,
                      input logic [31:0] act, input logic [31:0] expv);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, expv);
      end
   endtask

   logic [7:0] seed = 8'h00;
   int         max_wait = 0;
   bit         stray_en = 1'b0;
   bit         mon_on = 1'b0;

   function automatic logic [7:0] mem_byte(input logic [15:0] a);
      logic [7:0] m;
      m = a[15:8] * 8'd37;
      return a[7:0] ^ m ^ seed ^ 8'h3C;
   endfunction

   function automatic logic [23:0] exp_word_val(input int n);
      logic [15:0] a;
      a = BASE + 16'(BPW * n);
      return {mem_byte(a + 16'd2), mem_byte(a + 16'd1), mem_byte(a)};
   endfunction

   // expectations shared between the responder and the main sequence
   logic [15:0] exp_addr = BASE;
   int          exp_word = 0;
   int          lane = 0;
   int          wait_left = 0;
   int          n_reads = 0;
   bit          high_taken = 1'b0;
   bit          prev_req = 1'b0, prev_valid = 1'b0;
   logic [15:0] prev_addr = '0;

   // responder and monitor: sample first, then drive for the next edge
   initial begin
      forever begin
         @(negedge clk);
         if (mon_on) begin
            chk(ram_we == high_taken, "R5", "write strobe timing", 32'(ram_we), 32'(high_taken));
            if (ram_we) begin
               chk(ram_addr == 9'(exp_word), "R5", "ram address order", 32'(ram_addr), 32'(exp_word));
               chk(ram_wdata == exp_word_val(exp_word), "R4", "packed word", 32'(ram_wdata),
                   32'(exp_word_val(exp_word)));
               exp_word++;
            end
            if (prev_req && !prev_valid)
               chk(ext_req && ext_addr == prev_addr, "R3", "request held while waiting",
                   {15'd0, ext_req, ext_addr}, {16'd1, prev_addr});
            if (ext_req)
               chk(ext_addr == exp_addr, "R2", "byte address", 32'(ext_addr), 32'(exp_addr));
         end
         high_taken = 1'b0;
         if (ext_req) begin
            if (wait_left == 0) begin
               ext_valid = 1'b1;
               ext_data  = mem_byte(ext_addr);
               wait_left = $urandom_range(0, max_wait);
               exp_addr  = exp_addr + 16'd1;
               n_reads++;
               lane++;
               if (lane == BPW) begin
                  lane = 0;
                  high_taken = 1'b1;
               end
            end else begin
               ext_valid = 1'b0;
               ext_data  = 8'h5C;
               wait_left--;
            end
         end else begin
            ext_valid = stray_en && ($urandom_range(0, 1) == 1);
            ext_data  = 8'hA5;
         end
         prev_req   = ext_req;
         prev_valid = ext_valid;
         prev_addr  = ext_addr;
      end
   end

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   endtask

   // watchdog
   initial begin
      repeat (150000) @(posedge clk);
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   task automatic begin_load();
      @(negedge clk);
      exp_addr  = BASE;
      exp_word  = 0;
      lane      = 0;
      n_reads   = 0;
      wait_left = 0;
      start     = 1'b1;
      @(negedge clk);
      start     = 1'b0;
   endtask

   task automatic await_done(input bit poke_busy);
      int cyc = 0;
      forever begin
         @(negedge clk);
         cyc++;
         if (poke_busy && cyc == 200) begin
            start = 1'b1;                  // R8: ignored mid-load
            @(negedge clk);
            start = 1'b0;
         end
         if (ram_we && ram_addr == 9'(DEPTH - 1)) begin
            @(negedge clk);
            chk(done == 1'b1, "R7", "done one cycle after last write", 32'(done), 32'd1);
            break;
         end
      end
   endtask

   initial begin
      // R1: reset state
      #(CLK_PERIOD * 3);
      chk(!done && !ext_req && !ram_we, "R1", "outputs during reset",
          {29'd0, done, ext_req, ram_we}, 32'd0);
      @(negedge clk);
      rst_n = 1'b1;
      // R6: stray valid pulses while idle
      stray_en = 1'b1;
      for (int i = 0; i < 20; i++) begin
         @(negedge clk);
         chk(!done && !ext_req && !ram_we, "R6", "idle ignores stray valid",
             {29'd0, done, ext_req, ram_we}, 32'd0);
      end
      mon_on = 1'b1;

      for (int r = 0; r < N_RUNS; r++) begin
         seed     = RUNS[r][15:8];
         max_wait = int'(RUNS[r][7:4]);
         stray_en = RUNS[r][0];
         begin_load();                     // R9 for r > 0: restart from done
         await_done(r == 1);
         chk(exp_word == DEPTH, "R10", "words written per load", 32'(exp_word), 32'(DEPTH));
         chk(n_reads == BPW * DEPTH, "R10", "bytes read per load", 32'(n_reads), 32'(BPW * DEPTH));
         chk(exp_addr == BASE + 16'(BPW * DEPTH), "R8", "sequence uninterrupted",
             32'(exp_addr), 32'(BASE + 16'(BPW * DEPTH)));
         stray_en = 1'b1;
         for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            chk(done && !ext_req && !ram_we, "R7", "done held and quiet",
                {29'd0, done, ext_req, ram_we}, 32'd4);
         end
      end
      finish_run();
   end

endmodule